// File: doc/BRIEF.md
# Multi-Mode Audio Serial Transmitter

This block turns parallel stereo PCM sample pairs into serial audio streams on one or more data lanes that share a bit clock, a word select and a frame-begin strobe. A producer hands over one left/right pair per lane through a valid/ready handshake. The block picks up the waiting pair at the start of each left slot. If no new pair has arrived, it sends the previous pair again.

Two framings are supported. The first is MSB-first with a one-bit delay after the word select edge. The second is right-justified, with 16, 18 or 20 significant bits. Three rates are supported: single, double and quad. In master mode the bit clock and word select come from one counter that runs on the core clock. The core clock runs at twice the audio clock, which is 256fs or 384fs. In slave mode the block follows an external bit clock and word select, both sampled into the core clock domain. Each lane has its own output enable, and a disabled lane is left floating.

Top module: `pcm_serial_tx`

## Requirements
- R1: While reset is held, `bclk_o` and `ws_o` are 1, `sdb_o` is 0, `in_ready` is 1, and every enabled lane drives 0.
- R2: In master mode each half period of `bclk_o` lasts a fixed number of core clock cycles. With `aclk_384`=0 this is 4, 2 or 1 for `speed` codes 00, 01 and 10. With `aclk_384`=1 it is 6, 3 or 2 for the same codes. The resulting bit clock is 64fs, 128fs, or 256fs/192fs in quad.
- R3: Each word select half holds 32 bit periods, except quad speed with `aclk_384`=1, which holds 24. `ws_o` low carries the left sample and high carries the right sample.
- R4: With `fmt`=00 the 20-bit sample is sent MSB first. It starts in the second bit period of the slot, and all other bit periods of the slot are 0.
- R5: With `fmt` codes 01, 10 and 11 the top 16, 18 or 20 bits of the sample are sent MSB first. They are right-justified so that their LSB falls in the last bit period before the word select edge, and all earlier bit periods are 0. At quad speed the `fmt` input is ignored and R4 framing is used.
- R6: `ws_o` and the lane data change only together with a falling edge of `bclk_o`, so a receiver can sample on the rising edge.
- R7: At quad speed (`speed`=10), `sdb_o` is 1 during the first bit period of every fourth left slot, starting with the first left slot after reset. At other speeds `sdb_o` stays 0.
- R8: `speed` code 11 behaves exactly like code 00.
- R9: A pair is taken when `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the next left slot begins. That frame sends the new pair, and frames with no new pair repeat the last pair.
- R10: A lane whose `lane_en` bit is 0 drives high impedance. An enabled lane never does.
- R11: With `master`=0, `bclk_o` and `ws_o` follow `ext_bclk` and `ext_ws` with a fixed delay. A change of `ext_ws` seen at a falling `ext_bclk` edge starts a new slot, and the slot length is taken from R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the audio clock rate |
| rst | input | 1 | Synchronous active-high reset |
| master | input | 1 | 1: generate bit clock and word select; 0: follow external ones |
| aclk_384 | input | 1 | Audio clock ratio: 0 = 256fs, 1 = 384fs |
| speed | input | 2 | 00 single, 01 double, 10 quad, 11 single |
| fmt | input | 2 | 00 one-bit-delayed MSB first; 01/10/11 right-justified 16/18/20 |
| lane_en | input | LANES | Per-lane output enable |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_ws | input | 1 | External word select (slave mode) |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pair holding register empty |
| in_left | input | LANES*SAMPLE_W | Left samples, lane i at bits i*SAMPLE_W upward |
| in_right | input | LANES*SAMPLE_W | Right samples, same packing |
| bclk_o | output | 1 | Bit clock out |
| ws_o | output | 1 | Word select out |
| sdb_o | output | 1 | Frame-begin strobe (quad speed only) |
| sd_o | output | LANES | Serial data per lane, floating when disabled |

## Verification
The master-mode sweep covers every speed code, both clock ratios and every format code. A receiver model on the bench measures each bit-clock half period and counts the bits in each word select half. It rebuilds each slot into a word and compares it with a value computed arithmetically from the requirement. This catches wrong dividers, a wrong slot length, framing that is off by one bit, and truncation of the wrong bits. The bench sends samples only in some frames, using all-ones, MSB-only and mixed patterns. This separates a correct repeat of the last pair from a stale or early load. One sweep leg disables a lane, and a separate slave-mode leg uses a slower external clock. Together they separate the tristate behaviour and slot tracking from the internal divider.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int HCNT_W = 3;
  localparam int POS_W  = 6;

  localparam logic [1:0] SPD_SINGLE = 2'b00;
  localparam logic [1:0] SPD_DOUBLE = 2'b01;
  localparam logic [1:0] SPD_QUAD   = 2'b10;

  localparam logic [1:0] FMT_DELAYED = 2'b00;

  // core-clock cycles per bit clock half period (core = 2x audio clock)
  function automatic logic [HCNT_W-1:0] half_period(input logic [1:0] spd, input logic r384);
    logic [HCNT_W-1:0] hp;
    case (spd)
      SPD_DOUBLE: hp = r384 ? HCNT_W'(3) : HCNT_W'(2);
      SPD_QUAD:   hp = r384 ? HCNT_W'(2) : HCNT_W'(1);
      default:    hp = r384 ? HCNT_W'(6) : HCNT_W'(4);
    endcase
    return hp;
  endfunction

  function automatic logic [POS_W-1:0] slot_bits(input logic [1:0] spd, input logic r384);
    return (spd == SPD_QUAD && r384) ? POS_W'(24) : POS_W'(32);
  endfunction

  function automatic logic [POS_W-1:0] rj_width(input logic [1:0] f);
    logic [POS_W-1:0] w;
    case (f)
      2'b01:   w = POS_W'(16);
      2'b10:   w = POS_W'(18);
      2'b11:   w = POS_W'(20);
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/pst_clkgen.sv
module pst_clkgen
  import pst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] speed,
  input  logic       aclk_384,
  output logic       bclk_m,
  output logic       ws_m
);
  logic [HCNT_W-1:0] hcnt;
  logic [HCNT_W-1:0] hlim;
  logic [POS_W-1:0]  slen;
  logic [POS_W:0]    bcnt;
  logic [POS_W:0]    bcnt_n;
  logic [POS_W:0]    flast;

  assign hlim  = half_period(speed, aclk_384) - HCNT_W'(1);
  assign slen  = slot_bits(speed, aclk_384);
  assign flast = {slen, 1'b0} - (POS_W+1)'(1);
  assign bcnt_n = (bcnt >= flast) ? '0 : bcnt + (POS_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt   <= '0;
      bclk_m <= 1'b1;
      bcnt   <= '1;
      ws_m   <= 1'b1;
    end else if (hcnt >= hlim) begin
      hcnt   <= '0;
      bclk_m <= ~bclk_m;
      if (bclk_m) begin
        bcnt <= bcnt_n;
        ws_m <= (bcnt_n >= {1'b0, slen});
      end
    end else begin
      hcnt <= hcnt + HCNT_W'(1);
    end
  end
endmodule

// File: rtl/pst_timing.sv
module pst_timing
  import pst_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic [1:0]       speed,
  input  logic             aclk_384,
  input  logic [1:0]       fmt,
  input  logic             bclk_m,
  input  logic             ws_m,
  input  logic             ext_bclk,
  input  logic             ext_ws,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             tick,
  output logic             capture,
  output logic             load,
  output logic             chan_n,
  output logic [POS_W-1:0] pos_n,
  output logic [POS_W-1:0] slen,
  output logic [1:0]       fmt_eff,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             sdb_o
);
  logic bs1, bs2, ws1, ws2;
  logic bclk_i, ws_i;
  logic ws_last, chan;
  logic [POS_W-1:0] pos;
  logic [1:0] fcnt;
  logic slot_start, left_start, is_quad;

  assign is_quad    = (speed == SPD_QUAD);
  assign bclk_i     = master ? bclk_m : bs2;
  assign ws_i       = master ? ws_m : ws2;
  assign tick       = bclk_o & ~bclk_i;
  assign slot_start = tick & (ws_i != ws_last);
  assign left_start = slot_start & ~ws_i;
  assign capture    = in_valid & in_ready;
  assign load       = left_start & ~in_ready;
  assign chan_n     = slot_start ? ws_i : chan;
  assign pos_n      = slot_start ? '0 : ((pos == '1) ? pos : pos + POS_W'(1));
  assign slen       = slot_bits(speed, aclk_384);
  assign fmt_eff    = is_quad ? FMT_DELAYED : fmt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bs1      <= 1'b1;
      bs2      <= 1'b1;
      ws1      <= 1'b1;
      ws2      <= 1'b1;
      bclk_o   <= 1'b1;
      ws_o     <= 1'b1;
      ws_last  <= 1'b1;
      chan     <= 1'b1;
      pos      <= '0;
      fcnt     <= '0;
      sdb_o    <= 1'b0;
      in_ready <= 1'b1;
    end else begin
      bs1    <= ext_bclk;
      bs2    <= bs1;
      ws1    <= ext_ws;
      ws2    <= ws1;
      bclk_o <= bclk_i;
      ws_o   <= ws_i;
      if (tick) begin
        ws_last <= ws_i;
        chan    <= chan_n;
        pos     <= pos_n;
        sdb_o   <= is_quad & left_start & (fcnt == 2'd0);
        if (left_start) fcnt <= fcnt + 2'd1;
      end
      if (capture) in_ready <= 1'b0;
      else if (load) in_ready <= 1'b1;
    end
  end
endmodule

// File: rtl/pst_lane.sv
module pst_lane
  import pst_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic                load,
  input  logic                tick,
  input  logic                chan_n,
  input  logic [POS_W-1:0]    pos_n,
  input  logic [POS_W-1:0]    slen,
  input  logic [1:0]          fmt_eff,
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  output logic                sd_q
);
  localparam logic [POS_W-1:0] SWV = POS_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] hold_l, hold_r, act_l, act_r, smp, sh;
  logic [POS_W-1:0]    first;
  logic                bit_n;

  always_comb begin
    smp   = chan_n ? (load ? hold_r : act_r) : (load ? hold_l : act_l);
    first = slen - rj_width(fmt_eff);
    sh    = '0;
    bit_n = 1'b0;
    if (fmt_eff == FMT_DELAYED) begin
      if (pos_n != '0 && pos_n <= SWV) begin
        sh    = smp >> (SWV - pos_n);
        bit_n = sh[0];
      end
    end else if (pos_n >= first && pos_n < slen) begin
      sh    = smp >> (SWV - POS_W'(1) - (pos_n - first));
      bit_n = sh[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l <= '0;
      hold_r <= '0;
      act_l  <= '0;
      act_r  <= '0;
      sd_q   <= 1'b0;
    end else begin
      if (capture) begin
        hold_l <= in_l;
        hold_r <= in_r;
      end
      if (load) begin
        act_l <= hold_l;
        act_r <= hold_r;
      end
      if (tick) sd_q <= bit_n;
    end
  end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pst_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int SAMPLE_W = 20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      master,
  input  logic                      aclk_384,
  input  logic [1:0]                speed,
  input  logic [1:0]                fmt,
  input  logic [LANES-1:0]          lane_en,
  input  logic                      ext_bclk,
  input  logic                      ext_ws,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*SAMPLE_W-1:0] in_left,
  input  logic [LANES*SAMPLE_W-1:0] in_right,
  output logic                      bclk_o,
  output logic                      ws_o,
  output logic                      sdb_o,
  output logic [LANES-1:0]          sd_o
);
  logic             bclk_m, ws_m, tick, capture, load, chan_n;
  logic [POS_W-1:0] pos_n, slen;
  logic [1:0]       fmt_eff;
  logic [LANES-1:0] sd_q;

  pst_clkgen u_clkgen (
    .clk(clk), .rst(rst), .speed(speed), .aclk_384(aclk_384),
    .bclk_m(bclk_m), .ws_m(ws_m)
  );

  pst_timing u_timing (
    .clk(clk), .rst(rst), .master(master), .speed(speed), .aclk_384(aclk_384),
    .fmt(fmt), .bclk_m(bclk_m), .ws_m(ws_m), .ext_bclk(ext_bclk), .ext_ws(ext_ws),
    .in_valid(in_valid), .in_ready(in_ready), .tick(tick), .capture(capture),
    .load(load), .chan_n(chan_n), .pos_n(pos_n), .slen(slen), .fmt_eff(fmt_eff),
    .bclk_o(bclk_o), .ws_o(ws_o), .sdb_o(sdb_o)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pst_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk(clk), .rst(rst), .capture(capture), .load(load), .tick(tick),
      .chan_n(chan_n), .pos_n(pos_n), .slen(slen), .fmt_eff(fmt_eff),
      .in_l(in_left[i*SAMPLE_W +: SAMPLE_W]), .in_r(in_right[i*SAMPLE_W +: SAMPLE_W]),
      .sd_q(sd_q[i])
    );
    assign sd_o[i] = lane_en[i] ? sd_q[i] : 1'bz;
  end
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       speed,
  input logic             bclk_o,
  input logic             ws_o,
  input logic             sdb_o,
  input logic [LANES-1:0] sd_q,
  input logic             in_valid,
  input logic             in_ready
);
  a_r7_strobe_quad_only: assert property (@(posedge clk) disable iff (rst)
    sdb_o |-> (speed == 2'b10));

  a_r7_strobe_at_left_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(sdb_o) |-> ($fell(bclk_o) && !ws_o));

  a_r6_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(ws_o) |-> $fell(bclk_o));

  a_r6_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_q) |-> $fell(bclk_o));

  a_r9_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind pcm_serial_tx pst_checker #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .speed(speed), .bclk_o(bclk_o), .ws_o(ws_o),
  .sdb_o(sdb_o), .sd_q(sd_q), .in_valid(in_valid), .in_ready(in_ready)
);

// File: tb/pcm_serial_tx_test.sv
module pcm_serial_tx_test;
  localparam int CLK_P = 10;
  localparam int LANES = 2;
  localparam int SW    = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master = 1'b1, aclk_384 = 1'b0;
  logic [1:0] speed = 2'b00, fmt = 2'b00;
  logic [LANES-1:0] lane_en = '1;
  logic ext_bclk = 1'b1, ext_ws = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES*SW-1:0] in_left = '0, in_right = '0;
  logic bclk_o, ws_o, sdb_o;
  logic [LANES-1:0] sd_o;

  pcm_serial_tx #(.LANES(LANES), .SAMPLE_W(SW)) uut (
    .clk(clk), .rst(rst), .master(master), .aclk_384(aclk_384), .speed(speed),
    .fmt(fmt), .lane_en(lane_en), .ext_bclk(ext_bclk), .ext_ws(ext_ws),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .bclk_o(bclk_o), .ws_o(ws_o), .sdb_o(sdb_o), .sd_o(sd_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // configuration expectations
  int exp_hp, exp_s, fe;
  bit quad, slave_run = 1'b0, mon_on = 1'b0;
  string hp_tag, s_tag, d_tag;

  // receiver model state
  logic [LANES-1:0][SW-1:0] pend_l, pend_r, cur_l, cur_r;
  logic [LANES-1:0][31:0]   slot;
  int frames, nbits, cyc_since;
  bit slot_ok, seen_t, prev_bclk, prev_ws;

  function automatic logic [31:0] exp_slot(input logic [SW-1:0] s, input int f, input int sb);
    if (f == 0) return 32'(s) << (sb - 1 - SW);
    return 32'(s) >> (SW - (14 + 2*f));
  endfunction

  function automatic logic [SW-1:0] pat(input int k, input int i, input bit ch);
    if (k % 4 == 1) return ch ? 20'h80000 : 20'hFFFFF;
    if (k % 4 == 3) return ch ? 20'h00001 : 20'hA5A5A;
    return SW'(((k + 3) * 32'h9E37) ^ (i * 32'h5A5A5) ^ (ch ? 32'hF0F0F : 32'h0));
  endfunction

  // external clock source for slave mode: half period 5 core cycles
  initial begin
    int sc, bitn;
    sc = 0; bitn = 63;
    forever begin
      @(negedge clk);
      if (slave_run) begin
        sc++;
        if (sc == 5) begin
          sc = 0;
          ext_bclk = ~ext_bclk;
          if (!ext_bclk) begin
            bitn = (bitn == 63) ? 0 : bitn + 1;
            ext_ws = (bitn >= 32);
          end
        end
      end else begin
        sc = 0; bitn = 63; ext_bclk = 1'b1; ext_ws = 1'b1;
      end
    end
  end

  // receiver model sampling away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      cyc_since++;
      if (bclk_o !== prev_bclk) begin
        if (seen_t) chk(cyc_since == exp_hp, hp_tag, cyc_since, exp_hp);
        seen_t = 1'b1;
        cyc_since = 0;
        if (bclk_o === 1'b1) begin
          for (int i = 0; i < LANES; i++) begin
            chk(lane_en[i] ? (sd_o[i] !== 1'bz) : (sd_o[i] === 1'bz), "R10",
                (sd_o[i] === 1'bz) ? 2 : 64'(sd_o[i]), lane_en[i] ? 0 : 2);
            slot[i] = {slot[i][30:0], sd_o[i] === 1'b1};
          end
          if (nbits == 0 && ws_o === 1'b0 && slot_ok)
            chk(sdb_o === (quad && ((frames - 1) % 4 == 0)), "R7", 64'(sdb_o),
                64'(quad && ((frames - 1) % 4 == 0)));
          else if (sdb_o !== 1'b0)
            chk(1'b0, "R7", 64'(sdb_o), 0);
          nbits++;
        end
      end
      if (ws_o !== prev_ws) begin
        if (slot_ok) begin
          chk(nbits == exp_s, s_tag, nbits, exp_s);
          for (int i = 0; i < LANES; i++)
            if (lane_en[i])
              chk(slot[i] == exp_slot(prev_ws ? cur_r[i] : cur_l[i], fe, exp_s), d_tag,
                  slot[i], exp_slot(prev_ws ? cur_r[i] : cur_l[i], fe, exp_s));
        end
        slot_ok = 1'b1;
        nbits = 0;
        slot = '0;
        if (ws_o === 1'b0) begin
          frames++;
          cur_l = pend_l;
          cur_r = pend_r;
        end
      end
      prev_bclk = bclk_o;
      prev_ws = ws_o;
    end
  end

  task automatic run_cfg(input bit m, input logic [1:0] sp, input bit r, input logic [1:0] f,
                         input logic [LANES-1:0] en, input int nfr);
    int k;
    mon_on = 1'b0; slave_run = 1'b0; rst = 1'b1;
    master = m; speed = sp; aclk_384 = r; fmt = f; lane_en = en;
    quad   = (sp == 2'b10);
    exp_hp = !m ? 5 : (sp == 2'b01) ? (r ? 3 : 2) : quad ? (r ? 2 : 1) : (r ? 6 : 4);
    exp_s  = (quad && r) ? 24 : 32;
    fe     = quad ? 0 : int'(f);
    hp_tag = !m ? "R11 half period" : (sp == 2'b11) ? "R8 half period" : "R2 half period";
    s_tag  = !m ? "R11 slot length" : "R3 slot length";
    d_tag  = (fe == 0) ? ((f != 0) ? "R5 quad forced R4 data, R9 pair" : "R4 data, R9 pair")
                       : "R5 data, R9 pair";
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bclk_o === 1'b1 && ws_o === 1'b1, "R1 clocks", {bclk_o, ws_o}, 2'b11);
    chk(sdb_o === 1'b0 && in_ready === 1'b1, "R1 strobe/ready", {sdb_o, in_ready}, 2'b01);
    for (int i = 0; i < LANES; i++)
      if (en[i]) chk(sd_o[i] === 1'b0, "R1 data", 64'(sd_o[i]), 0);
    pend_l = '0; pend_r = '0; cur_l = '0; cur_r = '0;
    frames = 0; nbits = 0; cyc_since = 0; slot = '0;
    slot_ok = 1'b0; seen_t = 1'b0; prev_bclk = 1'b1; prev_ws = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    slave_run = !m;
    k = 0;
    while (frames < nfr) begin
      @(posedge ws_o);
      if (frames % 3 != 2 && frames < nfr) begin
        @(negedge clk);
        chk(in_ready === 1'b1, "R9 ready before offer", 64'(in_ready), 1);
        for (int i = 0; i < LANES; i++) begin
          in_left[i*SW +: SW]  = pat(k, i, 1'b0);
          in_right[i*SW +: SW] = pat(k, i, 1'b1);
        end
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready === 1'b0, "R9 ready after take", 64'(in_ready), 0);
        for (int i = 0; i < LANES; i++) begin
          pend_l[i] = pat(k, i, 1'b0);
          pend_r[i] = pat(k, i, 1'b1);
        end
        k++;
      end
    end
    mon_on = 1'b0;
    slave_run = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int sp = 0; sp < 4; sp++)
      for (int r = 0; r < 2; r++)
        for (int f = 0; f < 4; f++)
          run_cfg(1'b1, 2'(sp), r[0], 2'(f), (f == 1) ? 2'b01 : 2'b11, (sp == 2) ? 9 : 4);
    // R11 slave mode with an external bit clock
    run_cfg(1'b0, 2'b00, 1'b0, 2'b00, 2'b11, 4);
    run_cfg(1'b0, 2'b00, 1'b0, 2'b10, 2'b10, 4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule